// File: doc/BRIEF.md
# Grouped-Bit Distributed Arithmetic FIR Filter

This block is a fixed-point FIR filter with a fixed set of K signed coefficients. It forms the dot product of the coefficients and the K most recent samples without any multiplier. On each clock it takes a group of BCF bits from every stored sample, at the same bit positions in each. The K groups are joined into a lookup address. The word read from the table already combines the weighted coefficient sums for every bit of that group. A shift-accumulate path combines the group words, from the lowest group to the highest. A full result therefore takes DW/BCF clocks instead of DW.

Samples are signed Q1.15. Each sample's top bit has negative weight, but the main table adds it with positive weight like every other bit. A second table is addressed by the K sign bits. It holds minus twice the coefficient sum for those bits. This correction is added once, while the top group is processed, and it turns the positive contribution into the required negative one. The full-precision sum is rounded to the nearest Q1.15 value, with exact halves rounded upward, and then saturated. The tables are built at elaboration from the coefficient parameter.

A sample is offered with `inValid` and is taken on a clock edge where `inReady` is high. The result appears on `outData`, with `outValid` high for exactly one clock.

Top module: `grouped_da_fir`

## Requirements
- R1: While reset is held and right after it is released, `outValid` is 0, `outData` is 0 and `inReady` is 1.
- R2: A sample is taken only on an edge where both `inValid` and `inReady` are 1. `inReady` is 0 from the edge after acceptance until the result has been delivered. A sample offered while `inReady` is 0 has no effect on any later result.
- R3: For each accepted sample, `outValid` is 1 for exactly one clock, DW/BCF+1 clock edges after the accepting edge.
- R4: `outData` equals the sum over k of A_k·x_k, where x_k is the sample accepted k acceptances earlier (k=0 is the newest). The sum is taken as integers of Q1.15 values, then divided by 2^15 with round-half-up, bit for bit.
- R5: Tap k holds the sample accepted k acceptances earlier. Every tap holds zero after reset. Taps change only when a sample is accepted.
- R6: A sample with its sign bit set counts with negative weight. For example, three samples of -32768 give -(A0+A1+A2).
- R7: Results above 32767 saturate to 32767, and results below -32768 saturate to -32768.
- R8: Builds with BCF of 1, 2 and 4 give identical `outData` for identical input streams. Only the latency in R3 differs.
- R9: A result exactly halfway between two Q1.15 codes rounds toward plus infinity. With A0=24576 and the other taps zero, a newest sample of 2 gives 2 and a newest sample of -2 gives -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | A new sample is offered |
| inData | input | DW | Signed Q1.15 sample |
| inReady | output | 1 | The block can take a sample on this edge |
| outValid | output | 1 | One-clock strobe marking a new result |
| outData | output | DW | Rounded, saturated Q1.15 filter result |

## Verification
The faults that matter corrupt the accumulator or the tap contents. Each shows at the port on the very next `outValid`.

A wrong group order, a wrong shift amount or a misplaced correction breaks the result for almost any stimulus. The sign-correction fault only shows once a sample has its top bit set, so negative full-scale and mixed-sign inputs are driven on purpose.

Delay-line faults show up in the impulse response, one result per following sample.

Control faults show up in the strobe position and pulse width, which are counted against the accepting edge. Running three group widths side by side exposes any fault that depends on the group width.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

  // Strobes from the sequencer to the arithmetic path
  typedef struct packed {
    logic load;       // sample accepted: shift taps, clear accumulator
    logic step;       // one bit group is folded into the accumulator
    logic applyCorr;  // this step also adds the sign correction
    logic finish;     // accumulator is complete: round and register
  } daStrobes_t;

endpackage

// File: rtl/dafir_lut.sv
// Constant lookup table, built at elaboration from the coefficients.
// GROUP_TBL=1: address = K slices of BCF bits, word = sum_i 2^i * sum_k A_k*bit
// GROUP_TBL=0: address = K sign bits, word = -2 * sum_k A_k*bit
module dafir_lut #(
  parameter int K         = 3,
  parameter int CW        = 16,
  parameter int BCF       = 2,
  parameter int AB        = K * BCF,
  parameter int WW        = 24,
  parameter bit GROUP_TBL = 1'b1,
  parameter logic [K*CW-1:0] COEFS = '0
) (
  input  logic [AB-1:0]        addr,
  output logic signed [WW-1:0] data
);
  localparam int DEPTH = 1 << AB;

  function automatic logic signed [WW-1:0] entryVal(input logic [31:0] idx);
    longint sum;
    longint c;
    sum = 0;
    for (int k = 0; k < K; k++) begin
      c = longint'($signed(COEFS[k*CW +: CW]));
      if (GROUP_TBL) begin
        for (int i = 0; i < BCF; i++) begin
          if (idx[k*BCF + i]) sum = sum + (c <<< i);
        end
      end else if (idx[k]) begin
        sum = sum - 2 * c;
      end
    end
    return WW'(sum);
  endfunction

  logic signed [WW-1:0] romArr [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_rom
    localparam logic signed [WW-1:0] ENTRY = entryVal(32'(e));
    assign romArr[e] = ENTRY;
  end

  assign data = romArr[addr];

endmodule

// File: rtl/dafir_ctrl.sv
module dafir_ctrl
  import dafir_pkg::*;
#(
  parameter int GROUPS = 8,
  parameter int GW     = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  output logic          inReady,
  output daStrobes_t    strobes,
  output logic [GW-1:0] grpIdx,
  output logic          outValid
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} ctrlState_t;

  ctrlState_t state;
  logic       lastGrp;

  assign lastGrp = (grpIdx == GW'(GROUPS - 1));
  assign inReady = (state == S_IDLE);

  always_comb begin
    strobes.load      = (state == S_IDLE) && inValid;
    strobes.step      = (state == S_RUN);
    strobes.applyCorr = (state == S_RUN) && lastGrp;
    strobes.finish    = (state == S_DONE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      grpIdx   <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= strobes.finish;
      unique case (state)
        S_IDLE: if (strobes.load) begin
          state  <= S_RUN;
          grpIdx <= '0;
        end
        S_RUN: begin
          if (lastGrp) state <= S_DONE;
          else grpIdx <= grpIdx + 1'b1;
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: once a sample is taken, the port stops offering ready
  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> !inReady);

  // R2: the result strobe coincides with ready being offered again
  p_ready_at_result_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inReady);

  // R3: the result strobe lasts a single cycle
  p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R3: groups advance by one per cycle, lowest first
  p_grp_advance_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !lastGrp) |=> (strobes.step && grpIdx == GW'($past(grpIdx) + 1'b1)));

endmodule

// File: rtl/dafir_datapath.sv
module dafir_datapath
  import dafir_pkg::*;
#(
  parameter int K      = 3,
  parameter int DW     = 16,
  parameter int CW     = 16,
  parameter int BCF    = 2,
  parameter int GROUPS = DW / BCF,
  parameter int GW     = 3,
  parameter logic [K*CW-1:0] COEFS = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  daStrobes_t           strobes,
  input  logic [GW-1:0]        grpIdx,
  input  logic signed [DW-1:0] inData,
  output logic signed [DW-1:0] outData
);
  localparam int KB    = $clog2(K + 1);
  localparam int AB    = K * BCF;
  localparam int WW    = CW + KB + BCF + 1;
  localparam int AW    = CW + DW + KB + 3;
  localparam int GUARD = DW - BCF;
  localparam logic signed [AW-1:0] QMAX = (AW'(1) <<< (DW - 1)) - AW'(1);
  localparam logic signed [AW-1:0] QMIN = ~QMAX;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (DW - 2);

  logic [K-1:0][DW-1:0] taps;
  logic [AB-1:0]        mainAddr;
  logic [K-1:0]         signAddr;
  logic signed [WW-1:0] mainWord;
  logic signed [WW-1:0] corrWord;
  logic signed [AW-1:0] wordExt;
  logic signed [AW-1:0] corrExt;
  logic signed [AW-1:0] acc;
  logic signed [AW-1:0] accNext;
  logic signed [AW-1:0] rounded;

  // Address former: the same bit group from every tap, tap 0 lowest
  for (genvar k = 0; k < K; k++) begin : g_addr
    assign mainAddr[k*BCF +: BCF] = taps[k][grpIdx*BCF +: BCF];
    assign signAddr[k]            = taps[k][DW-1];
  end

  dafir_lut #(
    .K(K), .CW(CW), .BCF(BCF), .AB(AB), .WW(WW),
    .GROUP_TBL(1'b1), .COEFS(COEFS)
  ) groupLut_i (
    .addr(mainAddr),
    .data(mainWord)
  );

  dafir_lut #(
    .K(K), .CW(CW), .BCF(1), .AB(K), .WW(WW),
    .GROUP_TBL(1'b0), .COEFS(COEFS)
  ) signLut_i (
    .addr(signAddr),
    .data(corrWord)
  );

  assign wordExt = {{(AW-WW){mainWord[WW-1]}}, mainWord};
  assign corrExt = {{(AW-WW){corrWord[WW-1]}}, corrWord};

  always_comb begin
    accNext = (acc >>> BCF) + (wordExt <<< GUARD);
    if (strobes.applyCorr) accNext = accNext + (corrExt <<< (DW - 1));
  end

  assign rounded = (acc + HALF) >>> (DW - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      taps    <= '0;
      acc     <= '0;
      outData <= '0;
    end else begin
      if (strobes.load) begin
        for (int k = K - 1; k > 0; k--) taps[k] <= taps[k-1];
        taps[0] <= inData;
        acc     <= '0;
      end else if (strobes.step) begin
        acc <= accNext;
      end
      if (strobes.finish) begin
        if (rounded > QMAX)      outData <= QMAX[DW-1:0];
        else if (rounded < QMIN) outData <= QMIN[DW-1:0];
        else                     outData <= rounded[DW-1:0];
      end
    end
  end

  // R5: the delay line moves only on an accepted sample
  p_hold_taps_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(taps));

  // R6: load, accumulate and finish never overlap, so the correction cannot land in a cleared or finished sum
  p_exclusive_r6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.step, strobes.finish}));

endmodule

// File: rtl/grouped_da_fir.sv
module grouped_da_fir
  import dafir_pkg::*;
#(
  parameter int K   = 3,
  parameter int DW  = 16,
  parameter int CW  = 16,
  parameter int BCF = 2,
  parameter logic [K*CW-1:0] COEFS = {16'sd12000, -16'sd15000, 16'sd24576}
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inData,
  output logic                 inReady,
  output logic                 outValid,
  output logic signed [DW-1:0] outData
);
  localparam int GROUPS = DW / BCF;
  localparam int GW     = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  daStrobes_t    strobes;
  logic [GW-1:0] grpIdx;

  dafir_ctrl #(
    .GROUPS(GROUPS), .GW(GW)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inReady (inReady),
    .strobes (strobes),
    .grpIdx  (grpIdx),
    .outValid(outValid)
  );

  dafir_datapath #(
    .K(K), .DW(DW), .CW(CW), .BCF(BCF),
    .GROUPS(GROUPS), .GW(GW), .COEFS(COEFS)
  ) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .grpIdx (grpIdx),
    .inData (inData),
    .outData(outData)
  );

endmodule

// File: tb/grouped_da_fir_tb_top.sv
module grouped_da_fir_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [47:0] COEFS = {16'sd12000, -16'sd15000, 16'sd24576};
  localparam longint COEF [3] = '{24576, -15000, 12000};
  localparam int LAT [3] = '{17, 9, 5};  // BCF 1, 2, 4

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [15:0] inData = '0;
  logic [2:0] rdy;
  logic [2:0] ov;
  logic signed [15:0] od [3];

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  int gotCnt [3] = '{0, 0, 0};
  int gotCyc [3];
  logic signed [15:0] gotData [3];
  longint hist [3] = '{0, 0, 0};

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  grouped_da_fir #(.BCF(1), .COEFS(COEFS)) dut_b1 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(rdy[0]), .outValid(ov[0]), .outData(od[0]));
  grouped_da_fir #(.BCF(2), .COEFS(COEFS)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(rdy[1]), .outValid(ov[1]), .outData(od[1]));
  grouped_da_fir #(.BCF(4), .COEFS(COEFS)) dut_b4 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(rdy[2]), .outValid(ov[2]), .outData(od[2]));

  always @(negedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (ov[i]) begin
        gotCnt[i]  = gotCnt[i] + 1;
        gotCyc[i]  = cyc;
        gotData[i] = od[i];
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model();
    longint y = 0;
    for (int k = 0; k < 3; k++) y += COEF[k] * hist[k];
    y = (y + 16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  // Offer one sample to all three builds; optionally offer junk while busy (R2)
  task automatic pushSample(input longint x, input string req, input bit junk,
                            output longint expOut);
    int base [3];
    int acc;
    int guard = 0;
    while (rdy != 3'b111 && guard < 100) begin @(negedge clk); guard++; end
    for (int i = 0; i < 3; i++) base[i] = gotCnt[i];
    inValid = 1'b1;
    inData  = 16'(x);
    acc = cyc + 1;
    @(negedge clk);
    inValid = 1'b0;
    if (junk) begin
      check(rdy == 3'b000, "R2 ready low while busy", longint'(rdy), 0);
      inValid = 1'b1;
      inData  = 16'sh5A5A;
      @(negedge clk);
      inValid = 1'b0;
    end
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = x;
    expOut = model();
    guard = 0;
    while ((gotCnt[0] == base[0] || gotCnt[1] == base[1] || gotCnt[2] == base[2]) && guard < 40) begin
      @(negedge clk); guard++;
    end
    @(negedge clk);  // one more cycle: a stretched strobe would count twice
    for (int i = 0; i < 3; i++) begin
      check(longint'(gotData[i]) == expOut, {req, " R4 R8 result"}, longint'(gotData[i]), expOut);
      check(gotCyc[i] - acc == LAT[i], "R3 latency", gotCyc[i] - acc, LAT[i]);
      check(gotCnt[i] == base[i] + 1, "R3 single strobe", gotCnt[i] - base[i], 1);
    end
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check(ov[i] == 1'b0, "R1 outValid in reset", ov[i], 0);
      check(od[i] == 16'sd0, "R1 outData in reset", od[i], 0);
    end
    rstN = 1'b1;
    @(negedge clk);
    check(rdy == 3'b111, "R1 ready after reset", rdy, 7);
  endtask

  task automatic test_impulse();
    longint e;
    pushSample(16384, "R5 impulse tap0", 1'b0, e);
    check(e == 12288, "R5 impulse model tap0", e, 12288);
    pushSample(0, "R5 impulse tap1", 1'b0, e);
    pushSample(0, "R5 impulse tap2", 1'b0, e);
    pushSample(0, "R5 impulse flushed", 1'b0, e);
    check(e == 0, "R5 impulse gone", e, 0);
  endtask

  task automatic test_patterns();
    longint e;
    longint vals [6] = '{1234, -5678, 32767, -1, 7, -20000};
    foreach (vals[n]) pushSample(vals[n], "R4 pattern", 1'b0, e);
  endtask

  task automatic test_ignore();
    longint e;
    pushSample(3000, "R2 before junk", 1'b1, e);
    pushSample(-3000, "R2 after junk", 1'b0, e);
  endtask

  task automatic test_negative();
    longint e;
    for (int n = 0; n < 3; n++) pushSample(-32768, "R6 negative full scale", 1'b0, e);
    check(e == -21576, "R6 sign weight", e, -21576);
  endtask

  task automatic test_saturate();
    longint e;
    pushSample(32767, "R7 sat", 1'b0, e);
    pushSample(-32768, "R7 sat", 1'b0, e);
    pushSample(32767, "R7 sat high", 1'b0, e);
    check(e == 32767, "R7 positive clip", e, 32767);
    pushSample(-32768, "R7 sat", 1'b0, e);
    pushSample(32767, "R7 sat", 1'b0, e);
    pushSample(-32768, "R7 sat low", 1'b0, e);
    check(e == -32768, "R7 negative clip", e, -32768);
  endtask

  task automatic test_round();
    longint e;
    pushSample(0, "R9 clear", 1'b0, e);
    pushSample(0, "R9 clear", 1'b0, e);
    pushSample(2, "R9 tie positive", 1'b0, e);
    check(e == 2, "R9 tie up", e, 2);
    pushSample(0, "R9 clear", 1'b0, e);
    pushSample(0, "R9 clear", 1'b0, e);
    pushSample(-2, "R9 tie negative", 1'b0, e);
    check(e == -1, "R9 tie toward plus infinity", e, -1);
  endtask

  initial begin
    test_reset();
    test_impulse();
    test_patterns();
    test_ignore();
    test_negative();
    test_saturate();
    test_round();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChecks++;
    nErr++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule